// File: doc/BRIEF.md
# Multi-channel DMA instruction frontend

This block sits between a core's accelerator offload port and a set of DMA backend channels. It decodes the custom DMA instructions the core sends: opcode 0101011, funct3 000, with the operation chosen by funct7. It keeps the staging state for the next transfer. That state is a 64-bit source address, a 64-bit destination address, a source stride, a destination stride and an outer repeat count. All channels share it.

A copy instruction builds a transfer descriptor from the staging state and the instruction operands. It sends the descriptor to the channel selected by config bits 4:2 and returns a transfer ID to the core. Each channel has its own ID space, so software can track a short transfer on one channel apart from a long one on another. A status instruction returns one of two values for a chosen channel: the last completed ID, or the channel's busy flag.

Results are written back one cycle after the instruction is accepted. A copy whose target channel cannot take a descriptor holds the offload handshake until that channel is ready.

Top module: `dma_issue_frontend`

## Requirements
- R1: After reset, no writeback and no descriptor valid are asserted, the offload port is ready, and every channel's completed-ID status reads 0.
- R2: funct7=0 loads the source address as {rs2, rs1}, and funct7=1 loads the destination address the same way (rs1 gives the low 32 bits). Both appear on the descriptor of later copies.
- R3: funct7=6 loads the source stride from rs1 and the destination stride from rs2. funct7=7 loads the repeat count from rs1. When config bit 1 is set, a copy carries these three values and asserts the 2D flag.
- R4: When config bit 1 is clear, the descriptor carries strides of 0 and a repeat count of 1, whatever is staged.
- R5: A copy (funct7=2 or funct7=3) sends the transfer size from rs1 and returns an ID to rd. The ID is one more than the previous ID issued on that channel, and each channel counts from 1 independently.
- R6: The copy config comes from the rs2 field, bits 24:20 of the instruction, for funct7=2, and from the low 5 bits of the rs2 value for funct7=3. Config bit 0 drives the decouple flag, bits 4:2 select the channel, and only that channel's descriptor valid is raised.
- R7: A copy or status selector naming a channel at or above the channel count targets channel 0.
- R8: While the target channel's ready input is low, a copy keeps its descriptor valid and holds the offload ready low. It produces no writeback until it is accepted, and the ID it then returns is unaffected by the wait.
- R9: A status query with selector bits 1:0 = 0 returns the number of completion pulses the selected channel has received.
- R10: A status query with selector bits 1:0 = 2 returns the selected channel's busy input as 0 or 1, and selector codes 1 and 3 return 0. The selector comes from the rs2 field for funct7=4 and from the rs2 value for funct7=5.
- R11: Copy and status results appear on the writeback port, with their rd, in the cycle after acceptance. An rd of 0 suppresses the writeback, but the copy still consumes an ID.
- R12: Words with another opcode or funct3, or with funct7 above 7, are accepted with no effect on the staging state, the descriptors or the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| off_valid_i | input | 1 | Offloaded instruction valid |
| off_ready_o | output | 1 | Offloaded instruction accepted |
| off_instr_i | input | 32 | Instruction word |
| off_rs1_i | input | XLEN | rs1 operand value |
| off_rs2_i | input | XLEN | rs2 operand value |
| wb_valid_o | output | 1 | Writeback valid |
| wb_rd_o | output | 5 | Writeback destination register |
| wb_data_o | output | XLEN | Writeback value |
| xfer_valid_o | output | NUM_CH | Descriptor valid, one per channel |
| xfer_ready_i | input | NUM_CH | Descriptor ready, one per channel |
| xfer_src_o | output | 2*XLEN | Descriptor source address |
| xfer_dst_o | output | 2*XLEN | Descriptor destination address |
| xfer_len_o | output | XLEN | Descriptor size in bytes |
| xfer_src_stride_o | output | XLEN | Descriptor source stride |
| xfer_dst_stride_o | output | XLEN | Descriptor destination stride |
| xfer_reps_o | output | XLEN | Descriptor outer repeat count |
| xfer_decouple_o | output | 1 | Decouple read and write handshakes |
| xfer_2d_o | output | 1 | Two-dimensional transfer |
| ch_done_i | input | NUM_CH | Completion pulse, one per channel |
| ch_busy_i | input | NUM_CH | Busy flag, one per channel |

## Verification
The hardest case to reach is a copy held off by a channel that is not ready. The bench must see the descriptor held, no writeback and a blocked handshake for several cycles, and then the correct ID once the channel is ready. The bench drops one channel's ready input, holds a copy to that channel across three cycles and checks the ports in each, then releases ready. The ID spaces are exercised in the same way. The bench interleaves copies and completion pulses across channels, and mixes in out-of-range selectors that must land on channel 0. This shows that each channel's issued and completed counts evolve only from that channel's own traffic.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

  localparam logic [6:0] OPC_DMA = 7'b0101011;
  localparam logic [2:0] F3_DMA  = 3'b000;

  typedef enum logic [2:0] {
    OP_SRC   = 3'd0,
    OP_DST   = 3'd1,
    OP_CPYI  = 3'd2,
    OP_CPYR  = 3'd3,
    OP_STATI = 3'd4,
    OP_STATR = 3'd5,
    OP_STRD  = 3'd6,
    OP_REPS  = 3'd7
  } dma_op_e;

  typedef enum logic [1:0] {
    Q_DONE = 2'd0,
    Q_RSV1 = 2'd1,
    Q_BUSY = 2'd2,
    Q_RSV3 = 2'd3
  } query_e;

  typedef struct packed {
    logic       hit;
    dma_op_e    op;
    logic [4:0] rd;
    logic [4:0] rs2f;
  } dec_t;

  // Channel number from config bits 4:2; out-of-range folds to channel 0.
  function automatic logic [2:0] sel_channel(logic [4:0] cfg, int unsigned nch);
    if ({29'd0, cfg[4:2]} >= nch[31:0]) return 3'd0;
    return cfg[4:2];
  endfunction

  function automatic logic op_is_copy(dma_op_e op);
    return (op == OP_CPYI) || (op == OP_CPYR);
  endfunction

  function automatic logic op_is_stat(dma_op_e op);
    return (op == OP_STATI) || (op == OP_STATR);
  endfunction

  function automatic logic op_cfg_imm(dma_op_e op);
    return (op == OP_CPYI) || (op == OP_STATI);
  endfunction

endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode
  import dmafe_pkg::*;
(
  input  logic [31:0] word_i,
  output dec_t        dec_o
);

  logic unused_rs1f;
  assign unused_rs1f = ^word_i[19:15];

  always_comb begin
    dec_o.hit  = (word_i[6:0] == OPC_DMA) && (word_i[14:12] == F3_DMA) &&
                 (word_i[31:28] == 4'd0);
    dec_o.op   = dma_op_e'(word_i[27:25]);
    dec_o.rd   = word_i[11:7];
    dec_o.rs2f = word_i[24:20];
  end

endmodule

// File: rtl/dmafe_stage.sv
module dmafe_stage
  import dmafe_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  dma_op_e           op_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  output logic [2*XLEN-1:0] src_o,
  output logic [2*XLEN-1:0] dst_o,
  output logic [XLEN-1:0]   sstride_o,
  output logic [XLEN-1:0]   dstride_o,
  output logic [XLEN-1:0]   reps_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o     <= '0;
      dst_o     <= '0;
      sstride_o <= '0;
      dstride_o <= '0;
      reps_o    <= '0;
    end else if (we_i) begin
      case (op_i)
        OP_SRC:  src_o <= {rs2_i, rs1_i};
        OP_DST:  dst_o <= {rs2_i, rs1_i};
        OP_STRD: begin
          sstride_o <= rs1_i;
          dstride_o <= rs2_i;
        end
        OP_REPS: reps_o <= rs1_i;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dmafe_chan.sv
module dmafe_chan #(
  parameter int unsigned IDW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_i,
  input  logic           done_i,
  output logic [IDW-1:0] next_id_o,
  output logic [IDW-1:0] done_id_o
);

  logic [IDW-1:0] issued_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q  <= '0;
      done_id_o <= '0;
    end else begin
      if (issue_i) issued_q <= issued_q + IDW'(1);
      if (done_i) done_id_o <= done_id_o + IDW'(1);
    end
  end

  // ID a copy accepted this cycle receives.
  assign next_id_o = issued_q + IDW'(1);

endmodule

// File: rtl/dma_issue_frontend.sv
module dma_issue_frontend
  import dmafe_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned XLEN   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              off_valid_i,
  output logic              off_ready_o,
  input  logic [31:0]       off_instr_i,
  input  logic [XLEN-1:0]   off_rs1_i,
  input  logic [XLEN-1:0]   off_rs2_i,
  output logic              wb_valid_o,
  output logic [4:0]        wb_rd_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic [NUM_CH-1:0] xfer_valid_o,
  input  logic [NUM_CH-1:0] xfer_ready_i,
  output logic [2*XLEN-1:0] xfer_src_o,
  output logic [2*XLEN-1:0] xfer_dst_o,
  output logic [XLEN-1:0]   xfer_len_o,
  output logic [XLEN-1:0]   xfer_src_stride_o,
  output logic [XLEN-1:0]   xfer_dst_stride_o,
  output logic [XLEN-1:0]   xfer_reps_o,
  output logic              xfer_decouple_o,
  output logic              xfer_2d_o,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_busy_i
);

  dec_t            dec;
  logic            is_cp_w, is_st_w;
  logic [4:0]      cfg_w;
  logic [2:0]      tgt_w;
  logic [NUM_CH-1:0] sel_oh_w;
  logic            accept_w, copy_fire_w;
  logic [XLEN-1:0] result_w;

  logic [2*XLEN-1:0] st_src, st_dst;
  logic [XLEN-1:0]   st_sstr, st_dstr, st_reps;

  logic [XLEN-1:0] next_ids [NUM_CH];
  logic [XLEN-1:0] done_ids [NUM_CH];

  dmafe_decode u_dec (
    .word_i (off_instr_i),
    .dec_o  (dec)
  );

  assign is_cp_w = dec.hit && op_is_copy(dec.op);
  assign is_st_w = dec.hit && op_is_stat(dec.op);
  assign cfg_w   = op_cfg_imm(dec.op) ? dec.rs2f : off_rs2_i[4:0];
  assign tgt_w   = sel_channel(cfg_w, NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign sel_oh_w[c]     = (tgt_w == 3'(c));
    assign xfer_valid_o[c] = off_valid_i && is_cp_w && sel_oh_w[c];
  end

  assign off_ready_o = !is_cp_w || (|(sel_oh_w & xfer_ready_i));
  assign accept_w    = off_valid_i && off_ready_o;
  assign copy_fire_w = accept_w && is_cp_w;

  dmafe_stage #(.XLEN(XLEN)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (accept_w && dec.hit),
    .op_i      (dec.op),
    .rs1_i     (off_rs1_i),
    .rs2_i     (off_rs2_i),
    .src_o     (st_src),
    .dst_o     (st_dst),
    .sstride_o (st_sstr),
    .dstride_o (st_dstr),
    .reps_o    (st_reps)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmafe_chan #(.IDW(XLEN)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (copy_fire_w && sel_oh_w[c]),
      .done_i    (ch_done_i[c]),
      .next_id_o (next_ids[c]),
      .done_id_o (done_ids[c])
    );
  end

  // Descriptor payload, shared by all channels.
  assign xfer_src_o        = st_src;
  assign xfer_dst_o        = st_dst;
  assign xfer_len_o        = off_rs1_i;
  assign xfer_decouple_o   = cfg_w[0];
  assign xfer_2d_o         = cfg_w[1];
  assign xfer_src_stride_o = cfg_w[1] ? st_sstr : '0;
  assign xfer_dst_stride_o = cfg_w[1] ? st_dstr : '0;
  assign xfer_reps_o       = cfg_w[1] ? st_reps : XLEN'(1);

  always_comb begin
    result_w = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_oh_w[c]) begin
        if (is_cp_w) begin
          result_w = next_ids[c];
        end else begin
          case (query_e'(cfg_w[1:0]))
            Q_DONE:  result_w = done_ids[c];
            Q_BUSY:  result_w = XLEN'(ch_busy_i[c]);
            default: result_w = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_rd_o    <= '0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= accept_w && (is_cp_w || is_st_w) && (dec.rd != 5'd0);
      wb_rd_o    <= dec.rd;
      wb_data_o  <= result_w;
    end
  end

endmodule

// File: rtl/dmafe_chk.sv
module dmafe_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned XLEN   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              off_ready_o,
  input logic              wb_valid_o,
  input logic [4:0]        wb_rd_o,
  input logic [NUM_CH-1:0] xfer_valid_o,
  input logic [NUM_CH-1:0] xfer_ready_i,
  input logic [XLEN-1:0]   xfer_reps_o,
  input logic [XLEN-1:0]   xfer_src_stride_o,
  input logic [XLEN-1:0]   xfer_dst_stride_o,
  input logic              xfer_2d_o,
  input logic              accept_w,
  input logic              copy_fire_w
);

  // R11: a writeback only follows an accepted instruction
  a_r11_wb_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(accept_w));

  // R11: x0 never receives a writeback
  a_r11_no_x0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_rd_o != 5'd0));

  // R6: at most one channel sees a descriptor
  a_r6_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(xfer_valid_o));

  // R8: a descriptor facing a busy channel blocks the handshake
  a_r8_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(xfer_valid_o & ~xfer_ready_i)) |-> (!off_ready_o && !copy_fire_w));

  // R5: an issued copy always hands a descriptor to a ready channel
  a_r5_fire_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_fire_w |-> (|(xfer_valid_o & xfer_ready_i)));

  // R4: a one-dimensional descriptor is flat
  a_r4_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|xfer_valid_o) && !xfer_2d_o) |->
      (xfer_reps_o == XLEN'(1) && xfer_src_stride_o == '0 && xfer_dst_stride_o == '0));

endmodule

bind dma_issue_frontend dmafe_chk #(.NUM_CH(NUM_CH), .XLEN(XLEN)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .off_ready_o       (off_ready_o),
  .wb_valid_o        (wb_valid_o),
  .wb_rd_o           (wb_rd_o),
  .xfer_valid_o      (xfer_valid_o),
  .xfer_ready_i      (xfer_ready_i),
  .xfer_reps_o       (xfer_reps_o),
  .xfer_src_stride_o (xfer_src_stride_o),
  .xfer_dst_stride_o (xfer_dst_stride_o),
  .xfer_2d_o         (xfer_2d_o),
  .accept_w          (accept_w),
  .copy_fire_w       (copy_fire_w)
);

// File: tb/dma_issue_frontend_tb.sv
module dma_issue_frontend_tb;

  localparam int NCH = 4;
  localparam int XL  = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           off_valid;
  logic           off_ready;
  logic [31:0]    off_instr;
  logic [XL-1:0]  off_rs1, off_rs2;
  logic           wb_valid;
  logic [4:0]     wb_rd;
  logic [XL-1:0]  wb_data;
  logic [NCH-1:0] xv, xr, done, busy;
  logic [2*XL-1:0] xsrc, xdst;
  logic [XL-1:0]  xlen, xss, xds, xreps;
  logic           xdec, x2d;

  dma_issue_frontend #(.NUM_CH(NCH), .XLEN(XL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .off_valid_i(off_valid), .off_ready_o(off_ready), .off_instr_i(off_instr),
    .off_rs1_i(off_rs1), .off_rs2_i(off_rs2),
    .wb_valid_o(wb_valid), .wb_rd_o(wb_rd), .wb_data_o(wb_data),
    .xfer_valid_o(xv), .xfer_ready_i(xr), .xfer_src_o(xsrc), .xfer_dst_o(xdst),
    .xfer_len_o(xlen), .xfer_src_stride_o(xss), .xfer_dst_stride_o(xds),
    .xfer_reps_o(xreps), .xfer_decouple_o(xdec), .xfer_2d_o(x2d),
    .ch_done_i(done), .ch_busy_i(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2f,
                                      input logic [4:0] rd);
    return {f7, r2f, 5'd0, 3'b000, rd, 7'b0101011};
  endfunction

  // Snapshot of the descriptor side and writeback side of one instruction.
  logic [NCH-1:0]  s_valid;
  logic [2*XL-1:0] s_src, s_dst;
  logic [XL-1:0]   s_len, s_ss, s_ds, s_reps;
  logic            s_dec, s_2d;
  logic            g_wb;
  logic [4:0]      g_rd;
  logic [XL-1:0]   g_data;

  task automatic issue(input logic [31:0] w, input logic [XL-1:0] a, input logic [XL-1:0] b);
    @(negedge clk);
    off_valid = 1'b1; off_instr = w; off_rs1 = a; off_rs2 = b;
    #1;
    s_valid = xv; s_src = xsrc; s_dst = xdst; s_len = xlen;
    s_ss = xss; s_ds = xds; s_reps = xreps; s_dec = xdec; s_2d = x2d;
    while (!off_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    off_valid = 1'b0;
    #1;
    g_wb = wb_valid; g_rd = wb_rd; g_data = wb_data;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    done = m;
    @(negedge clk);
    done = '0;
  endtask

  typedef struct packed {
    logic [6:0]  f7;
    logic [4:0]  r2f;
    logic [4:0]  rd;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  bz;
    logic        expw;
    logic [31:0] expd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{7'd0, 5'd0,  5'd0,  32'h1000_0040, 32'h2, 4'h0, 1'b0, 32'd0}, // R2 set src
    '{7'd1, 5'd0,  5'd0,  32'h2000_0080, 32'h1, 4'h0, 1'b0, 32'd0}, // R2 set dst
    '{7'd2, 5'd0,  5'd10, 32'd64,        32'h0, 4'h0, 1'b1, 32'd1}, // R5 ch0
    '{7'd2, 5'd4,  5'd10, 32'd64,        32'h0, 4'h0, 1'b1, 32'd1}, // R5 ch1
    '{7'd3, 5'd0,  5'd11, 32'd64,        32'h4, 4'h0, 1'b1, 32'd2}, // R6 reg cfg ch1
    '{7'd2, 5'd0,  5'd12, 32'd64,        32'h0, 4'h0, 1'b1, 32'd2}, // R5 ch0
    '{7'd4, 5'd0,  5'd5,  32'd0,         32'h0, 4'h0, 1'b1, 32'd0}, // R9 done ch0
    '{7'd4, 5'd2,  5'd5,  32'd0,         32'h0, 4'h1, 1'b1, 32'd1}, // R10 busy ch0
    '{7'd4, 5'd6,  5'd5,  32'd0,         32'h0, 4'h1, 1'b1, 32'd0}, // R10 busy ch1
    '{7'd5, 5'd0,  5'd6,  32'd0,         32'h6, 4'h2, 1'b1, 32'd1}, // R10 reg sel ch1
    '{7'd2, 5'd12, 5'd7,  32'd64,        32'h0, 4'h0, 1'b1, 32'd1}, // R5 ch3
    '{7'd4, 5'd1,  5'd8,  32'd0,         32'h0, 4'hF, 1'b1, 32'd0}  // R10 code 1
  };

  function automatic string vtag(input logic [6:0] f7);
    case (f7)
      7'd0, 7'd1: return "R2";
      7'd2:       return "R5";
      7'd3:       return "R6";
      7'd4:       return "R9/R10 imm";
      default:    return "R10 reg";
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; off_valid = 1'b0; off_instr = '0; off_rs1 = '0; off_rs2 = '0;
    xr = '1; done = '0; busy = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 wb_valid after reset", {63'd0, wb_valid}, 64'd0);
    chk("R1 xfer_valid after reset", {60'd0, xv}, 64'd0);
    chk("R1 ready after reset", {63'd0, off_ready}, 64'd1);
    rst_n = 1'b1;
    issue(enc(7'd4, 5'd12, 5'd4), 0, 0);
    chk("R1 ch3 completed id zero", {32'd0, g_data}, 64'd0);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      busy = VT[i].bz;
      issue(enc(VT[i].f7, VT[i].r2f, VT[i].rd), VT[i].a, VT[i].b);
      chk($sformatf("%s vec%0d wb_valid", vtag(VT[i].f7), i), {63'd0, g_wb}, {63'd0, VT[i].expw});
      if (VT[i].expw) begin
        chk($sformatf("%s vec%0d data", vtag(VT[i].f7), i), {32'd0, g_data}, {32'd0, VT[i].expd});
        chk($sformatf("R11 vec%0d rd", i), {59'd0, g_rd}, {59'd0, VT[i].rd});
      end
    end
    busy = '0;
    // ids so far: ch0=2 ch1=2 ch2=0 ch3=1

    // R2/R4/R6: 1D decoupled copy to ch2 with strides staged
    issue(enc(7'd0, 5'd0, 5'd0), 32'hCAFE_0000, 32'h12);
    issue(enc(7'd1, 5'd0, 5'd0), 32'hBEEF_0100, 32'h34);
    issue(enc(7'd6, 5'd0, 5'd0), 32'd16, 32'd32);
    issue(enc(7'd7, 5'd0, 5'd0), 32'd8, 32'd0);
    issue(enc(7'd2, 5'b01001, 5'd3), 32'd256, 32'd0);
    chk("R6 valid on ch2 only", {60'd0, s_valid}, 64'h4);
    chk("R2 source address", s_src, {32'h12, 32'hCAFE_0000});
    chk("R2 destination address", s_dst, {32'h34, 32'hBEEF_0100});
    chk("R5 size from rs1", {32'd0, s_len}, 64'd256);
    chk("R6 decouple bit", {63'd0, s_dec}, 64'd1);
    chk("R4 reps forced to 1", {32'd0, s_reps}, 64'd1);
    chk("R4 src stride zero", {32'd0, s_ss}, 64'd0);
    chk("R4 dst stride zero", {32'd0, s_ds}, 64'd0);
    chk("R5 ch2 first id", {32'd0, g_data}, 64'd1);

    // R3: 2D copy via register config to ch0
    issue(enc(7'd3, 5'd0, 5'd3), 32'd64, 32'b00010);
    chk("R3 valid on ch0", {60'd0, s_valid}, 64'h1);
    chk("R3 2d flag", {63'd0, s_2d}, 64'd1);
    chk("R3 reps", {32'd0, s_reps}, 64'd8);
    chk("R3 src stride", {32'd0, s_ss}, 64'd16);
    chk("R3 dst stride", {32'd0, s_ds}, 64'd32);
    chk("R5 ch0 third id", {32'd0, g_data}, 64'd3);

    // R7: channels 7 and 4 fold to ch0
    issue(enc(7'd2, 5'b11100, 5'd3), 32'd8, 32'd0);
    chk("R7 ch7 maps to ch0 valid", {60'd0, s_valid}, 64'h1);
    chk("R7 ch7 maps to ch0 id", {32'd0, g_data}, 64'd4);
    issue(enc(7'd2, 5'b10000, 5'd3), 32'd8, 32'd0);
    chk("R7 ch4 maps to ch0 id", {32'd0, g_data}, 64'd5);

    // R8: stall on ch1
    xr = 4'b1101;
    @(negedge clk);
    off_valid = 1'b1; off_instr = enc(7'd2, 5'b00100, 5'd7); off_rs1 = 32'd4; off_rs2 = 0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 ready held low", {63'd0, off_ready}, 64'd0);
      chk("R8 descriptor held", {60'd0, xv}, 64'h2);
      chk("R8 no writeback while stalled", {63'd0, wb_valid}, 64'd0);
      @(negedge clk);
    end
    xr = '1;
    @(posedge clk);
    @(negedge clk);
    off_valid = 1'b0;
    #1;
    chk("R8 writeback after release", {63'd0, wb_valid}, 64'd1);
    chk("R8 id after stall", {32'd0, wb_data}, 64'd3);

    // R9: completion counts per channel
    pulse(4'b0010);
    pulse(4'b0011);
    issue(enc(7'd4, 5'b00100, 5'd5), 0, 0);
    chk("R9 ch1 completed", {32'd0, g_data}, 64'd2);
    issue(enc(7'd4, 5'b00000, 5'd5), 0, 0);
    chk("R9 ch0 completed", {32'd0, g_data}, 64'd1);
    issue(enc(7'd5, 5'd0, 5'd5), 0, 32'b01000);
    chk("R9 ch2 completed", {32'd0, g_data}, 64'd0);
    issue(enc(7'd4, 5'b11100, 5'd5), 0, 0);
    chk("R7 status ch7 reads ch0", {32'd0, g_data}, 64'd1);

    // R11: rd x0 suppresses writeback but consumes an id
    issue(enc(7'd2, 5'b01100, 5'd0), 32'd4, 0);
    chk("R11 rd0 no writeback", {63'd0, g_wb}, 64'd0);
    issue(enc(7'd2, 5'b01100, 5'd9), 32'd4, 0);
    chk("R11 rd echoed", {59'd0, g_rd}, 64'd9);
    chk("R11 id consumed by rd0 copy", {32'd0, g_data}, 64'd3);

    // R12: foreign opcode / funct3 / funct7 ignored
    issue({7'd0, 5'd0, 5'd0, 3'b000, 5'd4, 7'b0110011}, 32'hDEAD, 32'h1);
    chk("R12 foreign opcode no wb", {63'd0, g_wb}, 64'd0);
    chk("R12 foreign opcode no desc", {60'd0, s_valid}, 64'd0);
    issue({7'd2, 5'd0, 5'd0, 3'b001, 5'd4, 7'b0101011}, 32'd4, 0);
    chk("R12 funct3 mismatch no desc", {60'd0, s_valid}, 64'd0);
    chk("R12 funct3 mismatch no wb", {63'd0, g_wb}, 64'd0);
    issue({7'd8, 5'd0, 5'd0, 3'b000, 5'd0, 7'b0101011}, 32'hF00D, 32'h9);
    issue(enc(7'd2, 5'b01000, 5'd4), 32'd4, 0);
    chk("R12 source untouched", s_src, {32'h12, 32'hCAFE_0000});
    chk("R12 ch2 id unaffected", {32'd0, g_data}, 64'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule